// File: doc/BRIEF.md
# Cache Line Maintenance Controller

This block carries out maintenance commands on single lines of a write-back data cache. A command names one of three actions (invalidate, clean or flush) and gives a byte address. The controller finds the line that holds that address, decides whether its contents must go back to memory, and then updates the line's valid and dirty flags. When a write-back is needed, the controller offers the line-aligned address and the whole line payload on a memory-side port and waits for that port to accept them. The controller ends each command with a one-cycle completion pulse. If the address lies in the uncacheable window, it gives a one-cycle fault pulse in place of the completion pulse.

The controller models the tag and state store internally as a small direct-mapped array. The array holds a tag, a valid flag, a dirty flag and one line of data per entry. An install port stands in for the cache's refill path so that lines can be placed into the array. A combinational probe port reports whether an address hits and whether that line is dirty. The controller takes one command at a time. While a command is in progress, the busy output is high, and both new commands and installs are ignored.

Top module: `lm_maint_ctrl`

## Requirements
- R1: After reset, busy, done, fault and wb_valid are all low, and no address hits on the probe port.
- R2: A line is selected by address bits [31:6], so any byte offset inside a 64-byte line selects the same line, and wb_addr always has its low 6 bits at zero.
- R3: Invalidate (req_op 2'b00) on a hit line clears the line's valid and dirty flags and never writes back, even when the line is dirty.
- R4: Clean (req_op 2'b01) on a hit line writes the line back only if it is dirty, then clears dirty and keeps the line valid.
- R5: Flush (req_op 2'b10) on a hit line writes the line back first if it is dirty, then clears both valid and dirty.
- R6: A command to an address that misses (entry invalid, or tag different) completes with done, with no write-back and no change to any line.
- R7: A command whose address lies in [32'hE000_0000, 32'hEFFF_FFFF] gives a one-cycle fault pulse in place of done, with no write-back and no change to any line. Addresses just outside that window are handled normally.
- R8: A command changes only the line it selects. Every other entry keeps its valid flag, dirty flag, tag and data.
- R9: busy rises on the cycle after a command is accepted and stays high through the cycle that carries done or fault. That end pulse lasts exactly one cycle, after which busy is low. A request made while busy is high is ignored.
- R10: While wb_valid is high and wb_ready is low, wb_valid stays high and wb_addr and wb_data stay unchanged. wb_data is the stored 512-bit line.
- R11: Op code 2'b11 is a no-op: it completes with done and changes no line, even when it hits.
- R12: An install (fill_valid) made while the controller is idle writes the given tag, data and dirty flag into the selected entry and marks it valid. An install made while busy, or to an uncacheable address, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request; accepted when busy is low |
| req_op | input | 2 | 00 invalidate, 01 clean, 10 flush, 11 no-op |
| req_addr | input | 32 | Byte address inside the target line |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle pulse for an uncacheable address |
| wb_valid | output | 1 | Write-back offered |
| wb_ready | input | 1 | Memory accepts the write-back |
| wb_addr | output | 32 | Line-aligned write-back address |
| wb_data | output | 512 | Line payload |
| fill_valid | input | 1 | Install a line (idle only) |
| fill_addr | input | 32 | Address of the line to install |
| fill_dirty | input | 1 | Dirty flag for the installed line |
| fill_data | input | 512 | Data for the installed line |
| probe_addr | input | 32 | Address to look up |
| probe_hit | output | 1 | Probe address is present and valid |
| probe_dirty | output | 1 | Probed line is present and dirty |

## Verification
Take the edge that accepts a command as edge zero. Three timings follow from it:
- A miss, a no-op or a fault gives its end pulse after the second edge.
- A hit with no write-back gives its end pulse after the third edge.
- A write-back starts offering wb_valid after the second edge; the end pulse then follows the second edge after the edge that samples wb_ready high.

The bench counts edges from acceptance and samples each cycle between edges. It compares the exact cycle of the end pulse with that arithmetic, and it counts the cycles in which wb_valid is high against the ready delay it chose. The probe port is combinational, so line state is read back in the same idle cycle that follows each command.

// File: rtl/lm_pkg.sv
package lm_pkg;

    typedef enum logic [1:0] {
        OP_INVAL = 2'b00,
        OP_CLEAN = 2'b01,
        OP_FLUSH = 2'b10,
        OP_NONE  = 2'b11
    } lm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WB,
        ST_UPDATE,
        ST_DONE
    } lm_state_e;

endpackage

// File: rtl/lm_region.sv
// Splits a byte address into line index and tag and flags the uncacheable window.
module lm_region #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int IDX_W  = 3,
    parameter logic [ADDR_W-1:0] UC_BASE  = 32'hE000_0000,
    parameter logic [ADDR_W-1:0] UC_LIMIT = 32'hEFFF_FFFF
) (
    input  logic [ADDR_W-1:0]              addr,
    output logic [IDX_W-1:0]               idx,
    output logic [ADDR_W-OFF_W-IDX_W-1:0]  tag,
    output logic                           uncached
);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    always_comb begin
        idx      = addr[OFF_W +: IDX_W];
        tag      = addr[ADDR_W-1 -: TAG_W];
        uncached = (addr >= UC_BASE) && (addr <= UC_LIMIT);
    end
endmodule

// File: rtl/lm_store.sv
// Direct-mapped tag/state/data store with one install port, one maintenance
// update port, one read port for the sequencer and one probe read port.
module lm_store #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3,
    parameter int TAG_W     = 23,
    parameter int LINE_W    = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_dirty,
    input  logic [LINE_W-1:0] wr_data,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_kill,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  pb_idx,
    output logic              pb_valid,
    output logic              pb_dirty,
    output logic [TAG_W-1:0]  pb_tag
);
    typedef struct {
        logic [NUM_LINES-1:0] valid;
        logic [NUM_LINES-1:0] dirty;
        logic [TAG_W-1:0]     tag  [NUM_LINES];
        logic [LINE_W-1:0]    data [NUM_LINES];
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (wr_en) begin
            store_d.valid[wr_idx] = 1'b1;
            store_d.dirty[wr_idx] = wr_dirty;
            store_d.tag[wr_idx]   = wr_tag;
            store_d.data[wr_idx]  = wr_data;
        end
        if (upd_en) begin
            store_d.dirty[upd_idx] = 1'b0;
            if (upd_kill) begin
                store_d.valid[upd_idx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q.valid <= '0;
            store_q.dirty <= '0;
            for (int i = 0; i < NUM_LINES; i++) begin
                store_q.tag[i]  <= '0;
                store_q.data[i] <= '0;
            end
        end else begin
            store_q <= store_d;
        end
    end

    assign rd_valid = store_q.valid[rd_idx];
    assign rd_dirty = store_q.dirty[rd_idx];
    assign rd_tag   = store_q.tag[rd_idx];
    assign rd_data  = store_q.data[rd_idx];
    assign pb_valid = store_q.valid[pb_idx];
    assign pb_dirty = store_q.dirty[pb_idx];
    assign pb_tag   = store_q.tag[pb_idx];
endmodule

// File: rtl/lm_seq.sv
// Command sequencer: accept, look up, optional write-back, update, report.
module lm_seq
    import lm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              uncached,
    input  logic              line_hit,
    input  logic              line_dirty,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic              wb_valid,
    output logic              upd_en,
    output logic              upd_kill
);
    typedef struct packed {
        lm_state_e         st;
        lm_op_e            op;
        logic [ADDR_W-1:0] addr;
        logic              fault;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        upd_en   = 1'b0;
        upd_kill = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.op    = lm_op_e'(req_op);
                    seq_d.addr  = req_addr;
                    seq_d.fault = 1'b0;
                    seq_d.st    = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (uncached) begin
                    seq_d.fault = 1'b1;
                    seq_d.st    = ST_DONE;
                end else if (seq_q.op == OP_NONE || !line_hit) begin
                    seq_d.st = ST_DONE;
                end else if (line_dirty && seq_q.op != OP_INVAL) begin
                    seq_d.st = ST_WB;
                end else begin
                    seq_d.st = ST_UPDATE;
                end
            end
            ST_WB: begin
                if (wb_ready) begin
                    seq_d.st = ST_UPDATE;
                end
            end
            ST_UPDATE: begin
                upd_en   = 1'b1;
                upd_kill = (seq_q.op != OP_CLEAN);
                seq_d.st = ST_DONE;
            end
            ST_DONE: begin
                seq_d.st = ST_IDLE;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st    <= ST_IDLE;
            seq_q.op    <= OP_NONE;
            seq_q.addr  <= '0;
            seq_q.fault <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cap_addr = seq_q.addr;
    assign busy     = (seq_q.st != ST_IDLE);
    assign done     = (seq_q.st == ST_DONE) && !seq_q.fault;
    assign fault    = (seq_q.st == ST_DONE) && seq_q.fault;
    assign wb_valid = (seq_q.st == ST_WB);
endmodule

// File: rtl/lm_maint_ctrl.sv
module lm_maint_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int NUM_LINES  = 8,
    parameter logic [ADDR_W-1:0] UC_BASE  = 32'hE000_0000,
    parameter logic [ADDR_W-1:0] UC_LIMIT = 32'hEFFF_FFFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [1:0]              req_op,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    busy,
    output logic                    done,
    output logic                    fault,
    output logic                    wb_valid,
    input  logic                    wb_ready,
    output logic [ADDR_W-1:0]       wb_addr,
    output logic [LINE_BYTES*8-1:0] wb_data,
    input  logic                    fill_valid,
    input  logic [ADDR_W-1:0]       fill_addr,
    input  logic                    fill_dirty,
    input  logic [LINE_BYTES*8-1:0] fill_data,
    input  logic [ADDR_W-1:0]       probe_addr,
    output logic                    probe_hit,
    output logic                    probe_dirty
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = LINE_BYTES * 8;

    logic [ADDR_W-1:0] cap_addr;
    logic [IDX_W-1:0]  cap_idx, fl_idx, pr_idx;
    logic [TAG_W-1:0]  cap_tag, fl_tag, pr_tag;
    logic              cap_uc, fl_uc, pr_uc;

    logic              rd_valid, rd_dirty, pb_valid, pb_dirty;
    logic [TAG_W-1:0]  rd_tag, pb_tag;
    logic [LINE_W-1:0] rd_data;
    logic              line_hit, upd_en, upd_kill, wr_en;

    lm_region #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
                .UC_BASE(UC_BASE), .UC_LIMIT(UC_LIMIT)) u_cap_region (
        .addr(cap_addr), .idx(cap_idx), .tag(cap_tag), .uncached(cap_uc));

    lm_region #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
                .UC_BASE(UC_BASE), .UC_LIMIT(UC_LIMIT)) u_fill_region (
        .addr(fill_addr), .idx(fl_idx), .tag(fl_tag), .uncached(fl_uc));

    lm_region #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
                .UC_BASE(UC_BASE), .UC_LIMIT(UC_LIMIT)) u_probe_region (
        .addr(probe_addr), .idx(pr_idx), .tag(pr_tag), .uncached(pr_uc));

    assign wr_en    = fill_valid && !busy && !fl_uc;
    assign line_hit = rd_valid && (rd_tag == cap_tag);

    lm_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W),
               .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(fl_idx), .wr_tag(fl_tag),
        .wr_dirty(fill_dirty), .wr_data(fill_data),
        .upd_en(upd_en), .upd_idx(cap_idx), .upd_kill(upd_kill),
        .rd_idx(cap_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .rd_tag(rd_tag), .rd_data(rd_data),
        .pb_idx(pr_idx), .pb_valid(pb_valid), .pb_dirty(pb_dirty),
        .pb_tag(pb_tag));

    lm_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .uncached(cap_uc), .line_hit(line_hit), .line_dirty(rd_dirty),
        .wb_ready(wb_ready), .cap_addr(cap_addr),
        .busy(busy), .done(done), .fault(fault), .wb_valid(wb_valid),
        .upd_en(upd_en), .upd_kill(upd_kill));

    assign wb_addr     = {cap_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign wb_data     = rd_data;
    assign probe_hit   = pb_valid && (pb_tag == pr_tag) && !pr_uc;
    assign probe_dirty = probe_hit && pb_dirty;
endmodule

// File: rtl/lm_maint_chk.sv
module lm_maint_chk #(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [LINE_W-1:0] wb_data
);
    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    assert_end_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> (!done && !fault && !busy));

    assert_fault_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fault);

    assert_wb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wb_valid && !done && !fault));
endmodule

bind lm_maint_ctrl lm_maint_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_BYTES*8)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .done(done), .fault(fault), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_data(wb_data));

// File: tb/lm_maint_ctrl_test.sv
module lm_maint_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [1:0]   req_op = 2'b00;
    logic [31:0]  req_addr = '0;
    logic         busy, done, fault, wb_valid;
    logic         wb_ready = 1'b0;
    logic [31:0]  wb_addr;
    logic [511:0] wb_data;
    logic         fill_valid = 1'b0;
    logic [31:0]  fill_addr = '0;
    logic         fill_dirty = 1'b0;
    logic [511:0] fill_data = '0;
    logic [31:0]  probe_addr = '0;
    logic         probe_hit, probe_dirty;

    int n_chk = 0;
    int n_fail = 0;

    bit           mv [8];
    bit           md [8];
    logic [22:0]  mt [8];
    logic [511:0] mdat [8];

    always #10 clk = ~clk;

    lm_maint_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .busy(busy), .done(done), .fault(fault),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
        .wb_data(wb_data), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_dirty(fill_dirty), .fill_data(fill_data),
        .probe_addr(probe_addr), .probe_hit(probe_hit), .probe_dirty(probe_dirty));

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic bit is_uc(input logic [31:0] a);
        return (a >= 32'hE000_0000) && (a <= 32'hEFFF_FFFF);
    endfunction

    function automatic logic [511:0] rnd_line();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [31:0] mk(input logic [22:0] t, input int i, input int o);
        return {t, i[2:0], o[5:0]};
    endfunction

    function automatic logic [31:0] rnd_addr();
        if ($urandom % 8 == 0) return 32'hE000_0000 + ($urandom & 32'h0FFF_FFFF);
        return mk(23'h40 + 23'($urandom % 3), int'($urandom % 8), int'($urandom % 64));
    endfunction

    // Probe every entry against the model (called at a negedge, controller idle).
    task automatic probe_all(input string rq);
        for (int i = 0; i < 8; i++) begin
            probe_addr = mk(mt[i], i, int'($urandom % 64));
            #1;
            chk(probe_hit == mv[i], rq, "probe hit", 64'(probe_hit), 64'(mv[i]));
            chk(probe_dirty == (mv[i] && md[i]), rq, "probe dirty",
                64'(probe_dirty), 64'(mv[i] && md[i]));
        end
    endtask

    task automatic do_fill(input logic [31:0] a, input bit dty, input logic [511:0] dat);
        fill_valid = 1'b1; fill_addr = a; fill_dirty = dty; fill_data = dat;
        @(posedge clk); @(negedge clk);
        fill_valid = 1'b0;
        if (!is_uc(a)) begin
            mv[a[8:6]] = 1'b1; md[a[8:6]] = dty; mt[a[8:6]] = a[31:9]; mdat[a[8:6]] = dat;
        end
    endtask

    // poke: 0 none, 1 extra request while busy, 2 install while busy
    task automatic run_op(input logic [1:0] op, input logic [31:0] a, input int d,
                          input int poke, input logic [31:0] pa);
        int idx = int'(a[8:6]);
        logic [22:0] tg = a[31:9];
        bit uc = is_uc(a);
        bit hit = !uc && op != 2'b11 && mv[idx] && mt[idx] == tg;
        bit need = hit && md[idx] && op != 2'b00;
        int elat = !hit ? 2 : (need ? 4 + d : 3);
        string rq = uc ? "R7" : (op == 2'b11 ? "R11" : (!hit ? "R6" :
                    (op == 2'b00 ? "R3" : (op == 2'b01 ? "R4" : "R5"))));
        logic [511:0] exp_dat = mdat[idx];
        int cyc = 1, lat = 0, wbcnt = 0;
        bit fin = 0, got_done = 0, got_fault = 0, unstable = 0;
        logic [31:0] wa = '0;
        logic [511:0] wd = '0;

        req_valid = 1'b1; req_op = op; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        while (!fin && cyc < 60) begin
            if (done || fault) begin
                fin = 1; lat = cyc; got_done = done; got_fault = fault;
            end
            if (wb_valid) begin
                wbcnt++;
                if (wbcnt == 1) begin wa = wb_addr; wd = wb_data; end
                else if (wa != wb_addr || wd != wb_data) unstable = 1;
            end
            wb_ready   = wb_valid && (wbcnt >= d + 1);
            req_valid  = (poke == 1 && cyc == 1);
            req_op     = 2'b00;
            req_addr   = pa;
            fill_valid = (poke == 2 && cyc == 1);
            fill_addr  = pa;
            fill_dirty = 1'b1;
            fill_data  = {16{32'h5A5A_A5A5}};
            if (!fin) begin @(posedge clk); @(negedge clk); cyc++; end
        end
        req_valid = 1'b0; fill_valid = 1'b0; wb_ready = 1'b0;
        chk(lat == elat, "R9", {rq, " completion cycle"}, 64'(lat), 64'(elat));
        chk(got_fault == uc, rq, "fault pulse", 64'(got_fault), 64'(uc));
        chk(got_done == !uc, rq, "done pulse", 64'(got_done), 64'(!uc));
        chk(wbcnt == (need ? d + 1 : 0), rq, "write-back cycles", 64'(wbcnt),
            64'(need ? d + 1 : 0));
        if (need) begin
            chk(wa == {tg, idx[2:0], 6'b0}, "R2", "write-back address", 64'(wa),
                64'({tg, idx[2:0], 6'b0}));
            chk(wd == exp_dat, rq, "write-back data", wd[63:0], exp_dat[63:0]);
            chk(!unstable, "R10", "write-back held stable", 64'(unstable), 64'd0);
        end
        if (hit) begin
            if (op != 2'b01) mv[idx] = 1'b0;
            md[idx] = 1'b0;
        end
        @(posedge clk); @(negedge clk);
        chk(!done && !fault && !busy, "R9", "one-cycle end pulse then idle",
            64'({done, fault, busy}), 64'd0);
        probe_all("R8");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) begin
            mv[i] = 0; md[i] = 0; mt[i] = '0; mdat[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !wb_valid, "R1", "outputs in reset",
            64'({busy, done, fault, wb_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        probe_all("R1");

        // install, then clean using an unaligned address (R2, R4, R10)
        do_fill(32'h0000_2040, 1'b1, rnd_line());
        probe_all("R12");
        run_op(2'b01, 32'h0000_207F, 2, 0, 0);
        run_op(2'b01, 32'h0000_2051, 0, 0, 0);          // R4: clean line, no write-back
        // invalidate discards dirty data (R3), repeat is a miss (R6)
        do_fill(32'h0000_2080, 1'b1, rnd_line());
        run_op(2'b00, 32'h0000_20A3, 0, 0, 0);
        run_op(2'b00, 32'h0000_2080, 0, 0, 0);
        // flush dirty and clean lines (R5)
        do_fill(32'h0000_20C0, 1'b1, rnd_line());
        run_op(2'b10, 32'h0000_20C8, 0, 0, 0);
        do_fill(32'h0000_20C0, 1'b0, rnd_line());
        run_op(2'b10, 32'h0000_20FF, 1, 0, 0);
        // uncacheable window edges (R7)
        do_fill(32'hDFFF_FFC0, 1'b1, rnd_line());
        run_op(2'b01, 32'hDFFF_FFFF, 1, 0, 0);
        run_op(2'b10, 32'hE000_0000, 0, 0, 0);
        run_op(2'b00, 32'hEFFF_FFFF, 0, 0, 0);
        do_fill(32'hF000_0000, 1'b1, rnd_line());
        run_op(2'b10, 32'hF000_0010, 3, 0, 0);
        do_fill(32'hE000_0040, 1'b1, rnd_line());       // R12: ignored install
        probe_all("R12");
        // no-op code on a dirty hit (R11)
        do_fill(32'h0000_2100, 1'b1, rnd_line());
        run_op(2'b11, 32'h0000_2100, 0, 0, 0);
        // request and install while busy are ignored (R9, R12)
        run_op(2'b01, 32'h0000_4000, 0, 1, 32'h0000_2100);
        run_op(2'b01, 32'h0000_4000, 0, 2, 32'h0000_3140);
        // tag mismatch on a valid entry is a miss (R6)
        do_fill(32'h0000_2180, 1'b1, rnd_line());
        run_op(2'b10, 32'h0000_6180, 0, 0, 0);

        for (int n = 0; n < 300; n++) begin
            if ($urandom % 10 < 3)
                do_fill(rnd_addr(), 1'($urandom % 2), rnd_line());
            else
                run_op(2'($urandom % 4), rnd_addr(), int'($urandom % 4), 0, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule